// File: doc/BRIEF.md
# Byte-Wide Arithmetic, Logic and Shift Unit

This unit performs one of sixteen data operations on an 8-bit first operand X and, for binary operations, a second operand Y. A 4-bit function code chooses the operation: four add or subtract forms (two of them consume the incoming carry), four bitwise forms, and eight single-position shift or rotate forms of X. The result S and an updated 8-bit flag byte are captured on the rising clock edge whenever the enable input is high.

The caller passes in the current flag byte. The unit reads the carry from bit 1 of that byte, rewrites Zero (bit 0), Carry (bit 1) and Parity (bit 2), and returns every other bit unchanged. The returned flag byte is meant to be written back into the flag register by the surrounding datapath. The reset input is asserted asynchronously, and its release is synchronised to the clock inside the unit.

Top module: `octet_alu`

## Requirements
- R1: While reset is asserted, and until the first enabled edge after release, `s_out` and `flags_out` read 0x00.
- R2: With `en` high, the operation selected by `func` is captured on the next rising edge. With `en` low, both outputs hold their values whatever the other inputs do.
- R3: `func`=0000 yields X+Y and `func`=0010 yields X+Y+C, where C is `flags_in[1]`. Both are taken modulo 256, and the carry out of bit 7 goes to flag bit 1.
- R4: `func`=0001 yields X−Y and `func`=0011 yields X−Y−C, both modulo 256. Flag bit 1 is set exactly when a borrow occurs, that is, when unsigned X is less than Y (plus C for 0011).
- R5: `func`=0100/0101/0110/0111 yield X OR Y, X XOR Y, X AND Y and NOT X. Flag bit 1 keeps the value of `flags_in[1]`.
- R6: `func`=1DTT shifts X by one place, left when D=1 and right when D=0. The bit that leaves (bit 7 on a left shift, bit 0 on a right shift) goes to flag bit 1.
- R7: TT=00 (logical) inserts a zero at the vacated end.
- R8: TT=01 (arithmetic) inserts a zero on a left shift and a copy of bit 7 on a right shift.
- R9: TT=10 (rotate through carry) inserts the value of `flags_in[1]` as it was before the operation.
- R10: TT=11 (plain rotate) inserts the bit that leaves.
- R11: For every operation, flag bit 0 is set exactly when S is 0x00. Flag bit 2 is set exactly when S holds an even number of ones.
- R12: For every operation, flag bits 7..3 equal `flags_in[7:3]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| en | input | 1 | Capture enable for result and flags |
| func | input | 4 | Operation code |
| x_in | input | WIDTH | First operand, and the only operand for NOT and shifts |
| y_in | input | WIDTH | Second operand |
| flags_in | input | 8 | Current flag byte; bit 1 supplies the carry-in |
| s_out | output | WIDTH | Registered result |
| flags_out | output | 8 | Registered updated flag byte |

## Verification
The bench builds the unit with WIDTH=8 and a two-stage reset synchroniser. With these values the full corner grid is within reach: every function code is applied to operands 0x00, 0xFF, 0x80, 0x7F and 0x01, with carry-in both clear and set. That grid reaches the wrap points of ADDC and SUBC, borrow exactly at equality, and the fill bits of every shift kind at both ends. Idle cycles are mixed in with changing inputs, and the upper flag bits carry varying patterns, so hold behaviour and pass-through are observed at the ports.

// File: rtl/octet_alu_pkg.sv
package octet_alu_pkg;

  localparam int FLAG_W = 8;
  localparam int FZ     = 0;
  localparam int FC     = 1;
  localparam int FP     = 2;

  typedef enum logic [1:0] {
    SH_LOGIC = 2'b00,
    SH_ARITH = 2'b01,
    SH_ROTC  = 2'b10,
    SH_ROTW  = 2'b11
  } shift_kind_e;

  typedef enum logic [1:0] {
    LG_OR  = 2'b00,
    LG_XOR = 2'b01,
    LG_AND = 2'b10,
    LG_NOT = 2'b11
  } logic_kind_e;

endpackage

// File: rtl/octet_alu_addsub.sv
module octet_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         use_cin,
  input  logic         subtract,
  output logic [W-1:0] res,
  output logic         cout
);

  localparam int EXT = W + 1;

  logic [EXT-1:0] a_ext;
  logic [EXT-1:0] b_ext;
  logic [EXT-1:0] c_ext;
  logic [EXT-1:0] wide;

  always_comb begin
    a_ext = {1'b0, a};
    b_ext = {1'b0, b};
    c_ext = {{W{1'b0}}, (cin & use_cin)};
    if (subtract) begin
      wide = a_ext - b_ext - c_ext;
    end else begin
      wide = a_ext + b_ext + c_ext;
    end
    res  = wide[W-1:0];
    cout = wide[W];
  end

endmodule

// File: rtl/octet_alu_shifter.sv
module octet_alu_shifter
  import octet_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         left,
  input  shift_kind_e  kind,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cout
);

  logic fill;

  always_comb begin
    cout = left ? a[W-1] : a[0];
    unique case (kind)
      SH_LOGIC: fill = 1'b0;
      SH_ARITH: fill = left ? 1'b0 : a[W-1];
      SH_ROTC:  fill = cin;
      SH_ROTW:  fill = cout;
      default:  fill = 1'b0;
    endcase
    if (left) begin
      res = {a[W-2:0], fill};
    end else begin
      res = {fill, a[W-1:1]};
    end
  end

  always_comb begin
    if (kind == SH_LOGIC) begin
      // R7
      logical_fill_chk: assert (left ? (res[0] == 1'b0) : (res[W-1] == 1'b0));
    end
  end

endmodule

// File: rtl/octet_alu.sv
module octet_alu
  import octet_alu_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [3:0]        func,
  input  logic [WIDTH-1:0]  x_in,
  input  logic [WIDTH-1:0]  y_in,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [WIDTH-1:0]  s_out,
  output logic [FLAG_W-1:0] flags_out
);

  // reset release synchroniser
  logic [SYNC_STAGES-1:0] rst_pipe;
  logic                   rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = rst_pipe[SYNC_STAGES-1];

  // operation decode
  logic is_shift;
  logic is_logic;

  assign is_shift = func[3];
  assign is_logic = (func[3:2] == 2'b01);

  // datapath slices
  logic [WIDTH-1:0] add_res;
  logic             add_cout;
  logic [WIDTH-1:0] sh_res;
  logic             sh_cout;
  logic [WIDTH-1:0] lg_res;

  octet_alu_addsub #(.W(WIDTH)) u_addsub (
    .a        (x_in),
    .b        (y_in),
    .cin      (flags_in[FC]),
    .use_cin  (func[1]),
    .subtract (func[0]),
    .res      (add_res),
    .cout     (add_cout)
  );

  octet_alu_shifter #(.W(WIDTH)) u_shifter (
    .a    (x_in),
    .left (func[2]),
    .kind (shift_kind_e'(func[1:0])),
    .cin  (flags_in[FC]),
    .res  (sh_res),
    .cout (sh_cout)
  );

  always_comb begin
    unique case (logic_kind_e'(func[1:0]))
      LG_OR:   lg_res = x_in | y_in;
      LG_XOR:  lg_res = x_in ^ y_in;
      LG_AND:  lg_res = x_in & y_in;
      LG_NOT:  lg_res = ~x_in;
      default: lg_res = '0;
    endcase
  end

  // next state
  logic [WIDTH-1:0]  nxt_s;
  logic [FLAG_W-1:0] nxt_f;
  logic              nxt_c;

  always_comb begin
    if (is_shift) begin
      nxt_s = sh_res;
      nxt_c = sh_cout;
    end else if (is_logic) begin
      nxt_s = lg_res;
      nxt_c = flags_in[FC];
    end else begin
      nxt_s = add_res;
      nxt_c = add_cout;
    end
    nxt_f     = flags_in;
    nxt_f[FZ] = (nxt_s == '0);
    nxt_f[FP] = ~(^nxt_s);
    nxt_f[FC] = nxt_c;
  end

  // registers
  logic [WIDTH-1:0]  s_q;
  logic [FLAG_W-1:0] f_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      s_q <= '0;
      f_q <= '0;
    end else if (en) begin
      s_q <= nxt_s;
      f_q <= nxt_f;
    end
  end

  assign s_out     = s_q;
  assign flags_out = f_q;

  // R2
  hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en |=> ($stable(s_out) && $stable(flags_out)));

  // R12
  upper_flags_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en |=> (flags_out[FLAG_W-1:3] == $past(flags_in[FLAG_W-1:3])));

  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en |=> (flags_out[FZ] == (s_out == '0)));

  // R5
  logic_carry_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && func[3:2] == 2'b01) |=> (flags_out[FC] == $past(flags_in[FC])));

  // R6
  shift_carry_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && func[3]) |=> (flags_out[FC] == $past(func[2] ? x_in[WIDTH-1] : x_in[0])));

endmodule

// File: tb/octet_alu_test.sv
module octet_alu_test;

  logic       clk;
  logic       rst_n;
  logic       en;
  logic [3:0] func;
  logic [7:0] x_in;
  logic [7:0] y_in;
  logic [7:0] flags_in;
  logic [7:0] s_out;
  logic [7:0] flags_out;

  octet_alu uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .func      (func),
    .x_in      (x_in),
    .y_in      (y_in),
    .flags_in  (flags_in),
    .s_out     (s_out),
    .flags_out (flags_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;
  int    exp_s    = 0;
  int    exp_f    = 0;
  string tag_s    = "R1";
  string tag_c    = "R1";
  string tag_zp   = "R1";
  string tag_up   = "R1";

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int ones(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n;
  endfunction

  task automatic model(input int f, input int x, input int y, input int fl,
                       output int s, output int fo);
    int c;
    int co;
    int ins;
    c  = (fl >> 1) & 1;
    co = c;
    ins = 0;
    if (f == 0)      begin s = x + y;         co = (s > 255) ? 1 : 0; end
    else if (f == 2) begin s = x + y + c;     co = (s > 255) ? 1 : 0; end
    else if (f == 1) begin s = x - y;         co = (x < y) ? 1 : 0; end
    else if (f == 3) begin s = x - y - c;     co = (x < y + c) ? 1 : 0; end
    else if (f == 4) s = x | y;
    else if (f == 5) s = x ^ y;
    else if (f == 6) s = x & y;
    else if (f == 7) s = ~x;
    else begin
      if (f & 4) begin
        co = (x >> 7) & 1;
        case (f & 3)
          0: ins = 0;
          1: ins = 0;
          2: ins = c;
          default: ins = co;
        endcase
        s = (x << 1) | ins;
      end else begin
        co = x & 1;
        case (f & 3)
          0: ins = 0;
          1: ins = (x >> 7) & 1;
          2: ins = c;
          default: ins = co;
        endcase
        s = (x >> 1) | (ins << 7);
      end
    end
    s  = s & 255;
    fo = fl & 8'hF8;
    if (s == 0) fo |= 1;
    if (co != 0) fo |= 2;
    if (ones(s) % 2 == 0) fo |= 4;
  endtask

  function automatic string op_tag(input int f);
    if (f == 0 || f == 2) return "R3";
    if (f == 1 || f == 3) return "R4";
    if (f < 8) return "R5";
    case (f & 3)
      0: return "R7";
      1: return "R8";
      2: return "R9";
      default: return "R10";
    endcase
  endfunction

  // one negedge: check what the last edge produced, then drive the next cycle
  task automatic step(input bit e, input int f, input int x, input int y, input int fl);
    int s;
    int fo;
    @(negedge clk);
    check(tag_s,  "result",      int'(s_out),            exp_s);
    check(tag_c,  "carry",       int'(flags_out[1]),     (exp_f >> 1) & 1);
    check(tag_zp, "zero/parity", int'({flags_out[2], flags_out[0]}),
          (((exp_f >> 2) & 1) << 1) | (exp_f & 1));
    check(tag_up, "upper flags", int'(flags_out[7:3]),   (exp_f >> 3) & 31);
    en       = e;
    func     = 4'(f);
    x_in     = 8'(x);
    y_in     = 8'(y);
    flags_in = 8'(fl);
    if (e) begin
      model(f, x, y, fl, s, fo);
      exp_s  = s;
      exp_f  = fo;
      tag_s  = op_tag(f);
      tag_c  = (f >= 8) ? "R6" : op_tag(f);
      tag_zp = "R11";
      tag_up = "R12";
    end else if (tag_s != "R1") begin
      tag_s  = "R2";
      tag_c  = "R2";
      tag_zp = "R2";
      tag_up = "R2";
    end
  endtask

  initial begin
    int xs[5] = '{8'h00, 8'hFF, 8'h80, 8'h7F, 8'h01};
    int ys[4] = '{8'h00, 8'hFF, 8'h01, 8'h80};
    int k = 0;
    rst_n    = 1'b0;
    en       = 1'b1;
    func     = 4'h0;
    x_in     = 8'hFF;
    y_in     = 8'h01;
    flags_in = 8'hFF;
    repeat (3) @(negedge clk);
    // R1: outputs are zero while held in reset
    check("R1", "reset result", int'(s_out), 0);
    check("R1", "reset flags",  int'(flags_out), 0);
    en = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) step(0, 7, 8'h00, 8'h00, 8'hFF);
    // corner grid over every code, operand pair and carry-in
    for (int f = 0; f < 16; f++) begin
      for (int xi = 0; xi < 5; xi++) begin
        for (int yi = 0; yi < 4; yi++) begin
          for (int c = 0; c < 2; c++) begin
            int fl = ((k * 37) & 8'hF8) | (c << 1) | (k & 5);
            k++;
            step(1, f, xs[xi], ys[yi], fl);
            if (k % 7 == 0) step(0, (f + 3) & 15, ~xs[xi] & 255, 8'h5A, ~fl & 255);
          end
        end
      end
    end
    // scattered operands with idle cycles mixed in
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 5) != 0, $urandom % 16, $urandom % 256, $urandom % 256, $urandom % 256);
    end
    step(0, 0, 0, 0, 0);
    finished = 1;
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule